// File: doc/BRIEF.md
# Management-Mode Entry Sequencer

This block watches an active-low management interrupt line that may change at any time relative to the core clock. It steps a small core model through entry into a privileged management mode. Once the request has been synchronized, the block asks an external context store to save the running state and waits until the store reports completion. Only then does it raise the management-mode flag. One cycle later it presents an acknowledge transaction on a request/ready bus port. After the bus accepts that transaction, it loads the handler entry address into the program-counter output with a one-cycle load strobe.

The same interrupt line also works as a strap at reset. If the line is low on the first clock edge after reset is released, the block disables its bus drivers and stays inert until the next reset. While the management flag is set, further interrupts are ignored. A mode-exit pulse, honoured only when no entry is in flight, clears the flag and re-arms the block.

Top module: `mgmt_entry_seq`

## Requirements
- R1: While `rst` is high and after it falls, with the interrupt line high, `save_req`, `mgmt_active`, `ack_valid` and `pc_load` are 0, `ack_code` is 0, `bus_oe` is 1 and `pc_value` equals the parameter `RESET_VEC`.
- R2: A low level on `irq_n` passes through `SYNC_STAGES` flops (default 2). `save_req` first reads 1 after the (`SYNC_STAGES`+1)-th rising edge following the fall of `irq_n`.
- R3: `save_req` stays 1 until `save_done` is sampled high. On that edge `save_req` drops and `mgmt_active` rises, so the context is saved before the mode is entered.
- R4: `ack_valid` rises exactly one cycle after `mgmt_active` rises. `ack_code` equals the parameter `ACK_CODE` (default 8'h5A) whenever `ack_valid` is 1, and 0 otherwise.
- R5: `ack_valid` holds at 1 until an edge samples `ack_ready` high, and reads 0 right after that edge.
- R6: In the cycle after the acknowledge handshake, `pc_load` is 1 for exactly one cycle and `pc_value` equals `HANDLER_ADDR`. `pc_value` keeps that value afterwards.
- R7: If `irq_n` is 0 on the first rising edge with `rst` low, `bus_oe` goes to 0 and stays 0 until the next reset. In that case no entry ever starts: `save_req`, `ack_valid`, `pc_load` and `mgmt_active` stay 0 and `pc_value` stays `RESET_VEC`. A later reset with `irq_n` high restores `bus_oe` to 1.
- R8: While `mgmt_active` is 1, a low `irq_n` starts no new entry. `mode_exit` clears `mgmt_active` at the next edge only when the sequencer is idle (not between `save_req` and `pc_load`). If `irq_n` is still low, a new `save_req` follows one cycle after the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 1 | Asynchronous active-low management interrupt; also the reset-time float strap |
| mode_exit | input | 1 | Pulse that clears the management flag when idle |
| save_req | output | 1 | Request to store the current context |
| save_done | input | 1 | Context store has finished |
| mgmt_active | output | 1 | Management-mode flag |
| ack_valid | output | 1 | Acknowledge transaction request on the bus port |
| ack_code | output | ACK_W | Acknowledge transaction code, zero when idle |
| ack_ready | input | 1 | Bus port accepts the acknowledge |
| pc_load | output | 1 | One-cycle strobe to load `pc_value` into the core |
| pc_value | output | ADDR_W | Program-counter value (reset vector or handler entry) |
| bus_oe | output | 1 | Bus driver enable; 0 means all bus outputs float |

## Verification
A sequencer stuck in or skipping a phase shows at the ports within one cycle. Examples are `save_req` dropping without `save_done`, `ack_valid` appearing alongside or before `mgmt_active`, or `pc_load` lasting two cycles. A wrong synchronizer depth shifts the first `save_req` by one edge, so an exact-cycle latency check catches it. A mislatched strap shows as a wrong `bus_oe` on the first cycle after reset release. A flag that fails to block re-entry shows as a fresh `save_req` while `mgmt_active` is high. Comparing every output on every cycle against a behavioural model catches all of these at the first diverging cycle.

// File: rtl/mmode_pkg.sv
package mmode_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SAVE  = 3'd1,
        PH_ENTER = 3'd2,
        PH_ACK   = 3'd3,
        PH_JUMP  = 3'd4
    } mm_phase_e;

    typedef struct packed {
        logic save_req;
        logic ack_req;
        logic pc_load;
        logic active;
    } mm_ctl_t;

    localparam mm_ctl_t MM_CTL_IDLE = '{save_req: 1'b0, ack_req: 1'b0, pc_load: 1'b0, active: 1'b0};

    function automatic mm_phase_e mm_next_phase(
        input mm_phase_e cur,
        input logic      start,
        input logic      saved,
        input logic      accepted
    );
        mm_phase_e nxt;
        nxt = cur;
        unique case (cur)
            PH_IDLE:  if (start)    nxt = PH_SAVE;
            PH_SAVE:  if (saved)    nxt = PH_ENTER;
            PH_ENTER:               nxt = PH_ACK;
            PH_ACK:   if (accepted) nxt = PH_JUMP;
            PH_JUMP:                nxt = PH_IDLE;
            default:                nxt = PH_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/mmode_sync.sv
module mmode_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic req
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b1;
                    else     chain_q[0] <= async_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b1;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign req = ~chain_q[STAGES-1];
endmodule

// File: rtl/mmode_strap.sv
module mmode_strap (
    input  logic clk,
    input  logic rst,
    input  logic line_n,
    output logic float_mode,
    output logic sampled
);
    logic armed_q;
    logic float_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
            float_q <= 1'b0;
        end else if (armed_q) begin
            armed_q <= 1'b0;
            float_q <= ~line_n;
        end
    end

    assign float_mode = float_q;
    assign sampled    = ~armed_q;
endmodule

// File: rtl/mmode_fsm.sv
module mmode_fsm
    import mmode_pkg::*;
#(
    parameter int              ADDR_W       = 32,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = '0,
    parameter logic [ADDR_W-1:0] RESET_VEC    = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              req,
    input  logic              save_done,
    input  logic              ack_ready,
    input  logic              mode_exit,
    output mm_ctl_t           ctl,
    output logic [ADDR_W-1:0] pc_q
);
    mm_phase_e phase_q, phase_d;
    logic      flag_q;
    logic      start;

    assign start   = enable & req & ~flag_q;
    assign phase_d = mm_next_phase(phase_q, start, save_done, ack_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            flag_q  <= 1'b0;
            pc_q    <= RESET_VEC;
        end else begin
            phase_q <= phase_d;
            if (phase_q == PH_SAVE && save_done)
                flag_q <= 1'b1;
            else if (phase_q == PH_IDLE && mode_exit)
                flag_q <= 1'b0;
            if (phase_q == PH_ACK && ack_ready)
                pc_q <= HANDLER_ADDR;
        end
    end

    always_comb begin
        ctl          = MM_CTL_IDLE;
        ctl.save_req = (phase_q == PH_SAVE);
        ctl.ack_req  = (phase_q == PH_ACK);
        ctl.pc_load  = (phase_q == PH_JUMP);
        ctl.active   = flag_q;
    end
endmodule

// File: rtl/mmode_busport.sv
module mmode_busport #(
    parameter int               ACK_W    = 8,
    parameter logic [ACK_W-1:0] ACK_CODE = '0
) (
    input  logic             float_mode,
    input  logic             ack_req,
    output logic             ack_valid,
    output logic [ACK_W-1:0] ack_code,
    output logic             bus_oe
);
    assign bus_oe    = ~float_mode;
    assign ack_valid = ack_req & ~float_mode;
    assign ack_code  = ack_valid ? ACK_CODE : '0;
endmodule

// File: rtl/mgmt_entry_seq.sv
module mgmt_entry_seq
    import mmode_pkg::*;
#(
    parameter int                SYNC_STAGES  = 2,
    parameter int                ADDR_W       = 32,
    parameter int                ACK_W        = 8,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 32'h0003_8000,
    parameter logic [ADDR_W-1:0] RESET_VEC    = 32'hFFFF_FFF0,
    parameter logic [ACK_W-1:0]  ACK_CODE     = 8'h5A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_n,
    input  logic              mode_exit,
    output logic              save_req,
    input  logic              save_done,
    output logic              mgmt_active,
    output logic              ack_valid,
    output logic [ACK_W-1:0]  ack_code,
    input  logic              ack_ready,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_value,
    output logic              bus_oe
);
    logic    req_sync;
    logic    float_mode;
    logic    strap_sampled;
    mm_ctl_t ctl;

    mmode_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (irq_n),
        .req     (req_sync)
    );

    mmode_strap u_strap (
        .clk        (clk),
        .rst        (rst),
        .line_n     (irq_n),
        .float_mode (float_mode),
        .sampled    (strap_sampled)
    );

    mmode_fsm #(
        .ADDR_W       (ADDR_W),
        .HANDLER_ADDR (HANDLER_ADDR),
        .RESET_VEC    (RESET_VEC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .enable    (strap_sampled & ~float_mode),
        .req       (req_sync),
        .save_done (save_done),
        .ack_ready (ack_ready),
        .mode_exit (mode_exit),
        .ctl       (ctl),
        .pc_q      (pc_value)
    );

    mmode_busport #(.ACK_W(ACK_W), .ACK_CODE(ACK_CODE)) u_bus (
        .float_mode (float_mode),
        .ack_req    (ctl.ack_req),
        .ack_valid  (ack_valid),
        .ack_code   (ack_code),
        .bus_oe     (bus_oe)
    );

    assign save_req    = ctl.save_req;
    assign pc_load     = ctl.pc_load;
    assign mgmt_active = ctl.active;
endmodule

// File: rtl/mgmt_entry_seq_chk.sv
module mgmt_entry_seq_chk #(
    parameter int                ADDR_W       = 32,
    parameter int                ACK_W        = 8,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              save_req,
    input logic              save_done,
    input logic              mgmt_active,
    input logic              ack_valid,
    input logic [ACK_W-1:0]  ack_code,
    input logic              ack_ready,
    input logic              pc_load,
    input logic [ADDR_W-1:0] pc_value,
    input logic              bus_oe
);
    // R3: flag only rises on an edge that completed a save
    assert_save_before_mode_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(mgmt_active) |-> $past(save_req && save_done));

    // R3: save request holds until completion
    assert_save_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (save_req && !save_done) |=> save_req);

    // R4: acknowledge only after the flag is already up
    assert_ack_after_mode_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_valid) |-> (mgmt_active && $past(mgmt_active)));

    // R4: code is zero when no transaction is offered
    assert_code_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !ack_valid |-> (ack_code == '0));

    // R5: request holds while not accepted
    assert_ack_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !ack_ready) |=> ack_valid);

    // R5: request dropped right after acceptance
    assert_ack_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_ready) |=> !ack_valid);

    // R6: jump follows the handshake and carries the handler address
    assert_jump_after_ack_R6: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> ($past(ack_valid && ack_ready) && pc_value == HANDLER_ADDR));

    // R6: load strobe lasts one cycle
    assert_jump_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !pc_load);

    // R7: floated bus means no activity at all
    assert_float_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> (!save_req && !ack_valid && !pc_load && !mgmt_active));

    // R7: strap value held once sampled
    assert_float_latched_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> $stable(bus_oe));

    // R8: no new save while in management mode
    assert_no_reentry_R8: assert property (@(posedge clk) disable iff (rst)
        mgmt_active |-> !save_req);
endmodule

bind mgmt_entry_seq mgmt_entry_seq_chk #(
    .ADDR_W       (ADDR_W),
    .ACK_W        (ACK_W),
    .HANDLER_ADDR (HANDLER_ADDR)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .save_req    (save_req),
    .save_done   (save_done),
    .mgmt_active (mgmt_active),
    .ack_valid   (ack_valid),
    .ack_code    (ack_code),
    .ack_ready   (ack_ready),
    .pc_load     (pc_load),
    .pc_value    (pc_value),
    .bus_oe      (bus_oe)
);

// File: tb/mgmt_entry_seq_bench.sv
module mgmt_entry_seq_bench;
    localparam logic [31:0] HANDLER = 32'h0003_8000;
    localparam logic [31:0] RSTVEC  = 32'hFFFF_FFF0;
    localparam logic [7:0]  CODE    = 8'h5A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_n = 1'b1;
    logic        mode_exit = 1'b0;
    logic        save_done = 1'b0;
    logic        ack_ready = 1'b0;
    logic        save_req, mgmt_active, ack_valid, pc_load, bus_oe;
    logic [7:0]  ack_code;
    logic [31:0] pc_value;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int save_dly = 0;
    int ack_dly = 0;
    int scnt = 0;
    int acnt = 0;
    int save_seen = 0;
    bit started = 0;
    bit done_flag = 0;

    // behavioural reference state
    bit   q_sync[$] = '{1'b1, 1'b1};
    bit   m_armed = 1, m_float = 0, m_flag = 0;
    int   m_ph = 0;
    logic [31:0] m_pc = RSTVEC;

    always #4 clk = ~clk;

    mgmt_entry_seq u_mgmt_entry_seq (
        .clk(clk), .rst(rst), .irq_n(irq_n), .mode_exit(mode_exit),
        .save_req(save_req), .save_done(save_done), .mgmt_active(mgmt_active),
        .ack_valid(ack_valid), .ack_code(ack_code), .ack_ready(ack_ready),
        .pc_load(pc_load), .pc_value(pc_value), .bus_oe(bus_oe)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        cyc++;
        started = 1;
        if (rst) begin
            q_sync = '{1'b1, 1'b1};
            m_armed = 1; m_float = 0; m_flag = 0; m_ph = 0; m_pc = RSTVEC;
        end else begin
            bit req, o_armed, o_float, o_flag;
            req = !q_sync[0];
            o_armed = m_armed; o_float = m_float; o_flag = m_flag;
            if (m_armed) begin m_float = !irq_n; m_armed = 0; end
            case (m_ph)
                0: begin
                    if (mode_exit) m_flag = 0;
                    if (!o_armed && !o_float && req && !o_flag) m_ph = 1;
                end
                1: if (save_done) begin m_ph = 2; m_flag = 1; end
                2: m_ph = 3;
                3: if (ack_ready) begin m_ph = 4; m_pc = HANDLER; end
                default: m_ph = 0;
            endcase
            void'(q_sync.pop_front());
            q_sync.push_back(irq_n);
        end
        if (cyc > 100000 && !done_flag) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            finish_run();
        end
    end

    // per-cycle comparison and responders, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            bit ev;
            ev = (m_ph == 3) && !m_float;
            chk("R3 save_req", save_req, m_ph == 1);
            chk("R3 mgmt_active", mgmt_active, m_flag);
            chk("R5 ack_valid", ack_valid, ev);
            chk("R4 ack_code", ack_code, ev ? CODE : 8'h00);
            chk("R6 pc_load", pc_load, m_ph == 4);
            chk("R6 pc_value", pc_value, m_pc);
            chk("R7 bus_oe", bus_oe, !m_float);
        end
        if (save_req) begin
            if (scnt == 0) save_seen++;
            save_done = (scnt >= save_dly);
            scnt++;
        end else begin
            scnt = 0; save_done = 0;
        end
        if (ack_valid) begin
            ack_ready = (acnt >= ack_dly);
            acnt++;
        end else begin
            acnt = 0; ack_ready = 0;
        end
    end

    task automatic do_reset(input logic line);
        @(negedge clk);
        rst = 1; irq_n = line; mode_exit = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic wait_load();
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (pc_load) break;
        end
    endtask

    initial begin
        // R1: reset state
        do_reset(1'b1);
        chk("R1 save_req", save_req, 0);
        chk("R1 mgmt_active", mgmt_active, 0);
        chk("R1 ack_valid", ack_valid, 0);
        chk("R1 pc_value", pc_value, RSTVEC);
        chk("R1 bus_oe", bus_oe, 1);

        // R2: synchronizer latency, then R3..R6 with slow responders
        save_dly = 3; ack_dly = 2;
        irq_n = 0;
        @(negedge clk); chk("R2 edge1", save_req, 0);
        @(negedge clk); chk("R2 edge2", save_req, 0);
        @(negedge clk); chk("R2 edge3", save_req, 1);
        wait_load();
        chk("R6 load seen", pc_load, 1);
        chk("R6 handler", pc_value, HANDLER);
        @(negedge clk); chk("R6 one pulse", pc_load, 0);

        // R8: interrupt still low while active is ignored
        save_seen = 0;
        repeat (10) @(negedge clk);
        chk("R8 ignored", save_seen, 0);
        chk("R8 still active", mgmt_active, 1);
        mode_exit = 1; @(negedge clk); mode_exit = 0;
        chk("R8 flag cleared", mgmt_active, 0);
        @(negedge clk); chk("R8 reentry", save_req, 1);

        // R8: exit during acknowledge wait is ignored
        ack_dly = 4;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ack_valid) break;
        end
        mode_exit = 1; @(negedge clk); mode_exit = 0;
        wait_load();
        irq_n = 1;
        @(negedge clk);
        chk("R8 exit mid-entry ignored", mgmt_active, 1);

        // fast responders, new entry after clean exit
        mode_exit = 1; @(negedge clk); mode_exit = 0;
        save_dly = 0; ack_dly = 0;
        repeat (4) @(negedge clk);
        chk("R8 idle after exit", mgmt_active, 0);
        irq_n = 0; @(negedge clk); irq_n = 1;
        wait_load();
        chk("R6 fast handler", pc_value, HANDLER);
        repeat (5) @(negedge clk);

        // R7: strap asserted at reset release
        do_reset(1'b0);
        chk("R7 float", bus_oe, 0);
        irq_n = 1; repeat (3) @(negedge clk);
        save_seen = 0;
        irq_n = 0; repeat (10) @(negedge clk);
        chk("R7 no entry", save_seen, 0);
        chk("R7 pc untouched", pc_value, RSTVEC);
        chk("R7 still float", bus_oe, 0);

        // R7/R1: normal reset restores drivers
        do_reset(1'b1);
        chk("R7 restored", bus_oe, 1);
        chk("R1 pc after reset", pc_value, RSTVEC);
        repeat (3) @(negedge clk);

        done_flag = 1;
        finish_run();
    end
endmodule